// File: doc/BRIEF.md
# Serial Clock Wait and Interrupt Timing Controller

This block sits beside a byte-oriented serial shifter. It decides on which rising edge of the serial clock the end-of-byte interrupt fires. It also decides whether the clock line is then pulled low to stall the bus until software lets it go.

Software controls it through one 8-bit register. The register holds:
- a two-bit wait mode,
- a self-clearing release bit,
- an idle clock-level bit,
- a sticky error flag for the forbidden mode code,
- a read-only copy of the synchronized clock line level.

The block does not drive the clock line directly. It produces an open-drain enable: 1 pulls the line low, 0 releases it. It also produces a one-cycle interrupt pulse.

The neighbouring transfer logic marks the first clock of each byte with `byte_start`. It raises `xfer_active` while a byte is moving.

Top module: `sclk_wait_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `reg_rdata` reads 0x00. The register layout is:
  - bits [1:0]: wait mode
  - bit 2: release (always reads 0)
  - bit 3: idle clock level
  - bit 4: error flag
  - bit 6: line level
  - bits 5 and 7: read 0
- R2: With wait mode 00, `irq` pulses after the 8th rising edge of `scl_in` in a byte. `scl_drive_low` stays 0 while `xfer_active` is 1.
- R3: With wait mode 10, `irq` pulses after the 8th rising edge. `scl_drive_low` is then held at 1 until a release.
- R4: With wait mode 11, no interrupt follows the 8th edge. `irq` pulses after the 9th edge, and `scl_drive_low` is then held at 1 until a release.
- R5: A write of mode 01 is stored as 00 and behaves as mode 00. It also sets the error flag in bit 4. The flag stays set until a write with bit 4 equal to 1 clears it. A write that both clears the flag and sets mode 01 leaves the flag set.
- R6: Writing 1 to bit 2 ends the wait: `scl_drive_low` falls within two cycles. Bit 2 always reads 0.
- R7: When not waiting and `xfer_active` is 0, `scl_drive_low` is the inverse of bit 3.
- R8: While waiting, `scl_drive_low` is 1 whatever bit 3 and `xfer_active` are.
- R9: Bit 6 follows the synchronized `scl_in` level. Writes to bit 6 have no effect.
- R10: At most one `irq` pulse, one cycle wide, occurs per byte. The edge count clears on `byte_start` and on a release, and rising edges during a wait are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| scl_in | input | 1 | Serial clock line level |
| xfer_active | input | 1 | A byte transfer is in progress |
| byte_start | input | 1 | Pulse at the start of each byte |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls the clock line low |
| irq | output | 1 | One-cycle end-of-byte interrupt |

## Verification
The bench targets the off-by-one between modes 10 and 11. A design that counts to the wrong edge fires one clock early or late, or fires in both places.

It sends ten clock pulses in mode 00. This catches a counter that wraps and raises a second interrupt in the same byte.

It writes the forbidden mode and reads it back. A design that stores 01 literally, or forgets the sticky flag, shows up at once.

It sets the idle level to "released" during a wait, and writes bit 6 while the line is low. These expose a wait that the idle level can override, and a status bit that software can write.

// File: rtl/sclk_wait_pkg.sv
package sclk_wait_pkg;
   localparam int REG_W = 8;
   // control register bit positions
   localparam int B_MODE_LO = 0;
   localparam int B_MODE_HI = 1;
   localparam int B_REL     = 2;
   localparam int B_IDLE    = 3;
   localparam int B_ERR     = 4;
   localparam int B_LINE    = 6;

   typedef enum logic [1:0] {
      MODE_NOWAIT = 2'b00,
      MODE_BAD    = 2'b01,
      MODE_WAIT8  = 2'b10,
      MODE_WAIT9  = 2'b11
   } wait_mode_e;
endpackage

// File: rtl/sclk_wait_line.sv
module sclk_wait_line #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic level,
   output logic rise
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;

   initial begin
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= scl_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], scl_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[SYNC_STAGES-1];
   end

   assign level = chain[SYNC_STAGES-1];
   assign rise  = level & ~prev;
endmodule

// File: rtl/sclk_wait_regs.sv
module sclk_wait_regs
   import sclk_wait_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             line_level,
   output logic [REG_W-1:0] rdata,
   output wait_mode_e       mode,
   output logic             idle_rel,
   output logic             rel_pulse,
   output logic             err
);
   logic [1:0] wmode;

   assign wmode = {wdata[B_MODE_HI], wdata[B_MODE_LO]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= MODE_NOWAIT;
         idle_rel  <= 1'b0;
         rel_pulse <= 1'b0;
         err       <= 1'b0;
      end else begin
         rel_pulse <= wr & wdata[B_REL];
         if (wr) begin
            idle_rel <= wdata[B_IDLE];
            mode     <= (wmode == MODE_BAD) ? MODE_NOWAIT : wait_mode_e'(wmode);
            if (wmode == MODE_BAD)  err <= 1'b1;
            else if (wdata[B_ERR])  err <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata                            = '0;
      rdata[B_MODE_HI:B_MODE_LO]       = mode;
      rdata[B_IDLE]                    = idle_rel;
      rdata[B_ERR]                     = err;
      rdata[B_LINE]                    = line_level;
   end

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode != MODE_BAD); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err && !(wr && wdata[B_ERR]) |=> err); // R5
   AST_REL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rel_pulse |-> $past(wr)); // R6
endmodule

// File: rtl/sclk_wait_cnt.sv
module sclk_wait_cnt
   import sclk_wait_pkg::*;
#(
   parameter int BITS_PER_BYTE = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise,
   input  logic       byte_start,
   input  logic       rel_pulse,
   input  wait_mode_e mode,
   output logic       irq,
   output logic       waiting
);
   localparam int CNT_W = $clog2(BITS_PER_BYTE + 2);
   localparam logic [CNT_W-1:0] TGT_SHORT = CNT_W'(BITS_PER_BYTE);
   localparam logic [CNT_W-1:0] TGT_LONG  = CNT_W'(BITS_PER_BYTE + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;
   logic             done;
   logic             hit;

   initial begin
      assert (BITS_PER_BYTE >= 2) else $error("BITS_PER_BYTE must be at least 2");
   end

   assign target = (mode == MODE_WAIT9) ? TGT_LONG : TGT_SHORT;
   assign hit    = rise && !done && !waiting && (cnt + 1'b1 == target);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         done    <= 1'b0;
         waiting <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= hit;
         if (rel_pulse) waiting <= 1'b0;
         else if (hit)  waiting <= mode[1];
         if (byte_start) begin
            cnt  <= '0;
            done <= 1'b0;
         end else if (rel_pulse) begin
            cnt <= '0;
         end else if (hit) begin
            cnt  <= '0;
            done <= 1'b1;
         end else if (rise && !done && !waiting) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R10
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < TGT_LONG); // R10
   AST_WAIT_ONLY_IN_WAIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(waiting) |-> $past(mode[1])); // R2
   AST_RELEASE_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      rel_pulse |=> !waiting); // R6
endmodule

// File: rtl/sclk_wait_ctl.sv
module sclk_wait_ctl
   import sclk_wait_pkg::*;
#(
   parameter int BITS_PER_BYTE = 8,
   parameter int SYNC_STAGES   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       scl_in,
   input  logic       xfer_active,
   input  logic       byte_start,
   output logic       scl_drive_low,
   output logic       irq
);
   logic       line_level;
   logic       line_rise;
   wait_mode_e mode;
   logic       idle_rel;
   logic       rel_pulse;
   logic       err;
   logic       waiting;

   sclk_wait_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
      .level(line_level), .rise(line_rise));

   sclk_wait_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .line_level(line_level), .rdata(reg_rdata), .mode(mode),
      .idle_rel(idle_rel), .rel_pulse(rel_pulse), .err(err));

   sclk_wait_cnt #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise(line_rise), .byte_start(byte_start),
      .rel_pulse(rel_pulse), .mode(mode), .irq(irq), .waiting(waiting));

   assign scl_drive_low = waiting | (~xfer_active & ~idle_rel);

   AST_WAIT_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> scl_drive_low); // R8
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !waiting && !xfer_active |-> (scl_drive_low == !reg_rdata[B_IDLE])); // R7
   AST_REL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[B_REL]); // R6
endmodule

// File: tb/test_sclk_wait_ctl.sv
module test_sclk_wait_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       scl_in = 1'b0;
   logic       xfer_active = 1'b0;
   logic       byte_start = 1'b0;
   logic       scl_drive_low;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   int irq_seen = 0;
   int irq_run = 0;
   int irq_wide = 0;

   always #5 clk = ~clk;

   sclk_wait_ctl i_sclk_wait_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .scl_in(scl_in), .xfer_active(xfer_active),
      .byte_start(byte_start), .scl_drive_low(scl_drive_low), .irq(irq));

   always @(negedge clk) begin
      if (irq) begin
         irq_seen++;
         irq_run++;
         if (irq_run > 1) irq_wide++;
      end else irq_run = 0;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic start_byte();
      @(negedge clk); byte_start = 1'b1; xfer_active = 1'b1; irq_seen = 0;
      @(negedge clk); byte_start = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         scl_in = 1'b1; repeat (3) @(negedge clk);
         scl_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   // {mode[1:0], pulses[3:0], expected irq count[1:0], expected wait}
   localparam logic [8:0] VEC [0:7] = '{
      {2'b00, 4'd8,  2'd1, 1'b0},
      {2'b00, 4'd7,  2'd0, 1'b0},
      {2'b00, 4'd10, 2'd1, 1'b0},
      {2'b10, 4'd8,  2'd1, 1'b1},
      {2'b10, 4'd7,  2'd0, 1'b0},
      {2'b11, 4'd8,  2'd0, 1'b0},
      {2'b11, 4'd9,  2'd1, 1'b1},
      {2'b01, 4'd8,  2'd1, 1'b0}
   };

   initial begin
      fork
         begin
            repeat (100000) @(negedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      check("R1 reset rdata", reg_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset rdata", reg_rdata, 8'h00);

      // table walk: bit 3 = 1 so the idle level is released
      for (int v = 0; v < 8; v++) begin
         logic [1:0] md;
         md = VEC[v][8:7];
         wr({4'b0000, 1'b1, 1'b0, md});
         start_byte();
         pulses(int'(VEC[v][6:3]));
         case (md)
            2'b00:   check("R2 irq count", irq_seen, int'(VEC[v][2:1]));
            2'b10:   check("R3 irq count", irq_seen, int'(VEC[v][2:1]));
            2'b11:   check("R4 irq count", irq_seen, int'(VEC[v][2:1]));
            default: check("R5 irq count", irq_seen, int'(VEC[v][2:1]));
         endcase
         check("R3 R4 drive low after byte", scl_drive_low, VEC[v][0]);
         wr(8'h0C);   // release, keep idle released
         check("R6 drive low after release", scl_drive_low, 0);
         xfer_active = 1'b0;
         wr(8'h18);   // clear the error flag, mode 00
      end
      check("R10 irq width", irq_wide, 0);

      // R5: forbidden mode reads back as 00 with the error flag set
      wr(8'h09);
      check("R5 readback", reg_rdata, 8'h18);
      wr(8'h08);
      check("R5 flag sticky", reg_rdata, 8'h18);
      wr(8'h18);
      check("R5 flag cleared", reg_rdata, 8'h08);
      wr(8'h19);
      check("R5 set wins over clear", reg_rdata, 8'h18);
      wr(8'h18);

      // R7: idle clock level
      xfer_active = 1'b0;
      wr(8'h00);
      check("R7 idle low", scl_drive_low, 1);
      wr(8'h08);
      check("R7 idle released", scl_drive_low, 0);

      // R9: bit 6 follows the line, writes ignored
      scl_in = 1'b0;
      wr(8'h48);
      check("R9 write ignored", reg_rdata, 8'h08);
      scl_in = 1'b1; repeat (3) @(negedge clk);
      check("R9 follows line", reg_rdata, 8'h48);
      scl_in = 1'b0; repeat (3) @(negedge clk);

      // R8 and R6: wait overrides idle release and inactive transfer
      wr(8'h0A);
      start_byte();
      pulses(8);
      xfer_active = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 wait overrides idle level", scl_drive_low, 1);
      check("R6 release reads zero", reg_rdata, 8'h0A);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h0E;
      @(negedge clk); reg_wr = 1'b0;
      @(negedge clk);
      check("R6 wait ends in two cycles", scl_drive_low, 0);
      check("R6 release bit reads zero", reg_rdata[2], 0);

      // R10: no second irq in the same byte after release; new byte counts again
      xfer_active = 1'b1; irq_seen = 0;
      pulses(8);
      check("R10 no second irq per byte", irq_seen, 0);
      wr(8'h0C);
      start_byte();
      pulses(8);
      check("R10 new byte irq", irq_seen, 1);
      wr(8'h0C);
      check("R10 irq width directed", irq_wide, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule